// File: doc/BRIEF.md
# Masked Port-Change Interrupt

This block watches seven port levels, the pins numbered 24 to 30 of a parallel I/O expander, for changes. A 7-bit mask register chooses which of these pins are watched. Arming the block copies the current pin levels into a snapshot. From then on, any watched pin that differs from its snapshot latches an active-high interrupt.

The interrupt is a single-shot event. Once it fires, detection turns itself off. The interrupt stays high until software reads or writes the mask register. After that, nothing more is reported until the block is armed again.

The raw pin levels pass through a synchronizer before they are compared. The interrupt level is available as a signal of its own. It also appears on pin 31 whenever that pin is configured as an output.

Top module: `port_change_irq`

## Requirements
- R1: Mask bit i (bit 0 is pin 24, bit 6 is pin 30) set to 1 makes pin 24+i monitored. A change on a pin whose mask bit is 0 never raises the interrupt.
- R2: Every arm pulse captures a fresh snapshot of the synchronized levels, even when detection is already armed.
- R3: An arm pulse drives the interrupt low on the following clock.
- R4: While armed, a mismatch on a monitored pin raises the interrupt on the third rising edge after the pin changes. A pin pulse lasting at least two clock periods is caught.
- R5: Once high, the interrupt stays high even if the pins return to their snapshot or change further.
- R6: A read strobe or a write strobe on the mask register clears the interrupt on the next clock. No other access except arming lowers it.
- R7: When a mismatch is detected, detection disarms itself. After the interrupt is cleared, pin changes have no effect until the next arm pulse.
- R8: A disarm pulse stops detection and leaves the interrupt level unchanged.
- R9: Pin 31 carries the interrupt when its output enable is 1 and is low otherwise. The interrupt output itself does not depend on that enable.
- R10: A mask write loads the seven data bits on the next clock. Read data is {1'b0, mask}, so bit 7 always reads 0.
- R11: Same-cycle priority. An arm pulse wins over a disarm pulse and over a mask access: detection stays armed and the interrupt goes low. A mask access wins over a mismatch detected in the same cycle: the interrupt stays low and detection is disarmed.
- R12: After reset the mask is 0x00, detection is disarmed and the interrupt and pin 31 are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_lvl_i | input | 7 | Raw levels of pins 24..30 (bit 0 = pin 24) |
| arm_i | input | 1 | Configuration written with detect-enable set |
| disarm_i | input | 1 | Configuration written with detect-enable clear |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_rd_i | input | 1 | Mask register read strobe |
| mask_wdata_i | input | 7 | Mask write data |
| mask_rdata_o | output | 8 | Mask read data, bit 7 zero |
| p31_oe_i | input | 1 | Pin 31 configured as output |
| irq_o | output | 1 | Interrupt level |
| port31_o | output | 1 | Level driven on pin 31 |

## Verification
Two pairs of events can land on the same edge: a mismatch and a mask access, and an arm pulse and a mask write. In the first case, the bench counts the synchronizer stages so that the read strobe lands exactly on the edge where the mismatch would latch. It then checks that the interrupt stays low for several cycles while the pins remain changed, which shows that detection was also disarmed. In the second case, the bench pulses arm and a mask write together, then changes a monitored pin and expects the interrupt. The interrupt can only rise if arming survived the access.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  localparam int unsigned WATCH_W    = 7;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/tdi_rst_sync.sv
module tdi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n_s = rst_q[1];
endmodule

// File: rtl/tdi_sync.sv
module tdi_sync #(
  parameter int unsigned W     = 7,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[DEPTH-1];
endmodule

// File: rtl/tdi_mask_reg.sv
module tdi_mask_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/tdi_detect.sv
module tdi_detect #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic         arm,
  input  logic         disarm,
  input  logic         access,
  output logic         irq
);
  logic [W-1:0] snap_q, snap_d;
  logic         armed_q, armed_d;
  logic         irq_q, irq_d;
  logic         hit;

  // a monitored pin differs from its snapshot while armed
  assign hit = armed_q & (|((lvl ^ snap_q) & mask));

  always_comb begin
    snap_d  = snap_q;
    armed_d = armed_q;
    irq_d   = irq_q;
    if (arm) begin
      // arm dominates disarm and mask access
      snap_d  = lvl;
      armed_d = 1'b1;
      irq_d   = 1'b0;
    end else begin
      // a hit consumes the armed state (one-shot)
      armed_d = armed_q & ~disarm & ~hit;
      // a mask access dominates a hit in the same cycle
      irq_d   = access ? 1'b0 : (irq_q | hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   snap_q <= '0;
    else if (arm) snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import tdi_pkg::*;
#(
  parameter int unsigned WATCH_W    = tdi_pkg::WATCH_W,
  parameter int unsigned SYNC_DEPTH = tdi_pkg::SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WATCH_W-1:0] port_lvl_i,
  input  logic               arm_i,
  input  logic               disarm_i,
  input  logic               mask_wr_i,
  input  logic               mask_rd_i,
  input  logic [WATCH_W-1:0] mask_wdata_i,
  output logic [WATCH_W:0]   mask_rdata_o,
  input  logic               p31_oe_i,
  output logic               irq_o,
  output logic               port31_o
);
  localparam int unsigned RD_W = WATCH_W + 1;

  logic               rst_n_s;
  logic [WATCH_W-1:0] lvl_s;
  logic [WATCH_W-1:0] mask_q;
  logic               mask_access;
  logic               irq;

  assign mask_access = mask_wr_i | mask_rd_i;

  tdi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  tdi_sync #(.W(WATCH_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (port_lvl_i),
    .q     (lvl_s)
  );

  tdi_mask_reg #(.W(WATCH_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (mask_wr_i),
    .wdata  (mask_wdata_i),
    .mask_q (mask_q)
  );

  tdi_detect #(.W(WATCH_W)) u_det (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .lvl    (lvl_s),
    .mask   (mask_q),
    .arm    (arm_i),
    .disarm (disarm_i),
    .access (mask_access),
    .irq    (irq)
  );

  assign mask_rdata_o = RD_W'({1'b0, mask_q});
  assign irq_o        = irq;
  assign port31_o     = irq & p31_oe_i;
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
  parameter int unsigned W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         arm,
  input logic         mask_wr,
  input logic         mask_rd,
  input logic [W-1:0] mask_wdata,
  input logic [W:0]   mask_rdata,
  input logic         p31_oe,
  input logic         irq,
  input logic         port31
);
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !irq); // R3

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr || mask_rd) |=> !irq); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !mask_wr && !mask_rd && !arm) |=> irq); // R5

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_rdata == {1'b0, $past(mask_wdata)})); // R10

  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !p31_oe |-> !port31); // R9

  AST_PIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (p31_oe && irq) |-> port31); // R9
endmodule

bind port_change_irq port_change_irq_chk #(.W(WATCH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .arm        (arm_i),
  .mask_wr    (mask_wr_i),
  .mask_rd    (mask_rd_i),
  .mask_wdata (mask_wdata_i),
  .mask_rdata (mask_rdata_o),
  .p31_oe     (p31_oe_i),
  .irq        (irq_o),
  .port31     (port31_o)
);

// File: tb/port_change_irq_test.sv
module port_change_irq_test;
  logic       clk;
  logic       rst_n;
  logic [6:0] port_lvl;
  logic       arm, disarm, mwr, mrd, oe;
  logic [6:0] wdata;
  logic [7:0] rdata;
  logic       irq, port31;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  port_change_irq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_lvl_i   (port_lvl),
    .arm_i        (arm),
    .disarm_i     (disarm),
    .mask_wr_i    (mwr),
    .mask_rd_i    (mrd),
    .mask_wdata_i (wdata),
    .mask_rdata_o (rdata),
    .p31_oe_i     (oe),
    .irq_o        (irq),
    .port31_o     (port31)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [6:0] port;
    logic       arm;
    logic       dis;
    logic       mwr;
    logic       mrd;
    logic [6:0] wd;
    logic       exp_irq;
    logic [6:0] exp_mask;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 7'h0F, 1'b0, 7'h0F}, // R10 mask load
    '{7'h00, 1'b1, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // arm, snap 00
    '{7'h10, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // R1 unmonitored pin
    '{7'h11, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b1, 7'h0F}, // R4 monitored pin
    '{7'h10, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b1, 7'h0F}, // R5 back to snapshot
    '{7'h10, 1'b0, 1'b0, 1'b0, 1'b1, 7'h00, 1'b0, 7'h0F}, // R6 read clears
    '{7'h11, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // R7 one-shot
    '{7'h11, 1'b1, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // re-arm, snap 11
    '{7'h13, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b1, 7'h0F}, // R4
    '{7'h13, 1'b1, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // R3 arm clears
    '{7'h13, 1'b0, 1'b1, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // R8 disarm
    '{7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h0F}, // R8 no detect
    '{7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 7'h40, 1'b0, 7'h40}, // R10
    '{7'h00, 1'b1, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h40}, // arm, snap 00
    '{7'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h40}, // R1 masked off
    '{7'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b1, 7'h40}, // R1 pin 30
    '{7'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 7'h7F, 1'b0, 7'h7F}, // R6 write clears
    '{7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0, 7'h7F}  // R7 one-shot
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic a, input logic d, input logic w, input logic r, input logic [6:0] wd);
    arm = a; disarm = d; mwr = w; mrd = r; wdata = wd;
    cyc(1);
    arm = 0; disarm = 0; mwr = 0; mrd = 0; wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; port_lvl = '0; arm = 0; disarm = 0; mwr = 0; mrd = 0;
    wdata = '0; oe = 1;
    cyc(3);
    rst_n = 1;
    cyc(4);
    // R12 reset state
    chk("R12 irq", {7'b0, irq}, 8'h00);
    chk("R12 port31", {7'b0, port31}, 8'h00);
    chk("R10 reset mask", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      port_lvl = VEC[i].port;
      pulse(VEC[i].arm, VEC[i].dis, VEC[i].mwr, VEC[i].mrd, VEC[i].wd);
      cyc(3);
      chk($sformatf("vec%0d irq (R1/R3-R8)", i), {7'b0, irq}, {7'b0, VEC[i].exp_irq});
      chk($sformatf("vec%0d R9 port31", i), {7'b0, port31}, {7'b0, VEC[i].exp_irq});
      chk($sformatf("vec%0d R10 rdata", i), rdata, {1'b0, VEC[i].exp_mask});
    end

    // R4: two-cycle pin pulse is caught; mask 7F, pins 00
    pulse(1, 0, 0, 0, '0);
    cyc(2);
    port_lvl = 7'h01; cyc(2); port_lvl = 7'h00;
    cyc(4);
    chk("R4 short pulse", {7'b0, irq}, 8'h01);
    // R9: enable off hides the pin, irq kept
    oe = 0; cyc(1);
    chk("R9 pin gated", {7'b0, port31}, 8'h00);
    chk("R9 irq independent", {7'b0, irq}, 8'h01);
    oe = 1; cyc(1);
    chk("R9 pin driven", {7'b0, port31}, 8'h01);
    // R8: disarm leaves irq as is
    pulse(0, 1, 0, 0, '0); cyc(2);
    chk("R8 irq kept", {7'b0, irq}, 8'h01);

    // R11: mask read on the same edge as a hit
    pulse(0, 0, 0, 1, '0);
    pulse(1, 0, 0, 0, '0); cyc(2);
    port_lvl = 7'h02; cyc(2);
    pulse(0, 0, 0, 1, '0);
    cyc(4);
    chk("R11 access beats hit", {7'b0, irq}, 8'h00);

    // R11: arm and mask write together keep detection armed
    pulse(1, 0, 1, 0, 7'h7F); cyc(2);
    chk("R10 rdata after joint write", rdata, 8'h7F);
    port_lvl = 7'h06; cyc(4);
    chk("R11 arm beats access", {7'b0, irq}, 8'h01);

    // R2: re-arm while armed takes a new snapshot
    pulse(0, 0, 0, 1, '0);
    pulse(0, 0, 1, 0, 7'h01);
    pulse(1, 0, 0, 0, '0); cyc(2);
    port_lvl = 7'h36; cyc(4);
    chk("R2 unwatched change", {7'b0, irq}, 8'h00);
    pulse(1, 0, 0, 0, '0); cyc(1);
    pulse(0, 0, 1, 0, 7'h7F); cyc(4);
    chk("R2 new snapshot", {7'b0, irq}, 8'h00);
    port_lvl = 7'h37; cyc(4);
    chk("R2 detect after re-arm", {7'b0, irq}, 8'h01);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule